// File: doc/BRIEF.md
# Data-Rate Select and Glitch-Free Rate Clock

This block sets the bit-rate reference of a disk controller. The host writes a two-bit rate code through a dedicated load strobe, with the write strobe active and the chip select held inactive. The code picks one of four power-of-two divisions of an internal reference. The reference itself runs at half the master clock. The chosen division drives the rate clock output, which the encoder and decoder use.

A change of code never cuts a pulse short. The switch stretches no pulse and makes no runt. First the output follows the old source to its next falling edge and then parks low. The block then waits through two falling edges of the new source. On that second falling edge it hands the output to the new source. Operation carries on across the change without any reset. A write that repeats the current code leaves the output untouched.

Top module: `rate_clk_sel`

## Requirements
- R1: During reset and right after it, `rate_code` is 00 and `rate_clk` is low. After reset the output runs at the code-00 rate.
- R2: At a rising clock edge where `ld_stb` and `wr_stb` are both high and `cs` is low, `bus_lo[1:0]` is captured. It shows on `rate_code` after that edge.
- R3: The register does not change when `cs` is high, when `ld_stb` is low, or when `wr_stb` is low.
- R4: In steady state, each high phase and each low phase of `rate_clk` lasts 2^code master cycles. Code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R5: Every high pulse of `rate_clk` has the full width of the source that produced it, including the pulses around a switch.
- R6: On a change of code, the output parks low at the next falling edge of the old source. It stays low until the second following falling edge of the new source, and then follows the new source. The low gap is therefore at least three new half-periods long.
- R7: A write of the code already in force starts no switch, and the output waveform goes on unbroken.
- R8: A code written while a switch is still running retargets that switch. The output settles to the rate of the last code written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_lo | input | 2 | Low bits of the host data bus |
| ld_stb | input | 1 | Rate register load strobe, active high |
| wr_stb | input | 1 | Host write strobe, active high |
| cs | input | 1 | Chip select, active high; blocks the load when high |
| rate_code | output | 2 | Rate code currently held |
| rate_clk | output | 1 | Generated rate clock |

## Verification
The pulse widths are measured for every code, in rising order (0, 2, 3), then falling order (3 to 0) and then to an adjacent step (0 to 1). This separates a wrong divider tap from a switch that mis-times its hand-over. Each change also records the longest low gap and checks it against the bounds set by the two-edge wait. A write that repeats the current code, and writes that are blocked by chip select or by a missing strobe, must leave that gap at the steady half-period. This sets them apart from writes that start a switch. Two codes written back to back show whether a switch in flight takes on the later code.

// File: rtl/rate_clk_pkg.sv
package rate_clk_pkg;

    localparam int CODE_W     = 2;
    localparam int NUM_RATES  = 1 << CODE_W;
    localparam int DIV_W      = NUM_RATES;
    localparam int WAIT_FALLS = 2;
    localparam int WCNT_W     = $clog2(WAIT_FALLS + 1);

    typedef logic [CODE_W-1:0] rate_code_t;
    typedef logic [DIV_W-1:0]  tap_vec_t;

    typedef enum logic [1:0] {
        SW_RUN   = 2'd0,
        SW_DRAIN = 2'd1,
        SW_WAIT  = 2'd2
    } sw_state_e;

    typedef struct packed {
        sw_state_e         state;
        rate_code_t        sel;
        logic [WCNT_W-1:0] falls;
    } sw_ctx_t;

    // Master cycles in one half period of a tap
    function automatic int half_cycles(input rate_code_t c);
        return 1 << c;
    endfunction

endpackage

// File: rtl/rate_code_reg.sv
module rate_code_reg
    import rate_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rate_code_t bus_lo,
    input  logic       ld_stb,
    input  logic       wr_stb,
    input  logic       cs,
    output rate_code_t code_o
);
    logic load_ok;
    assign load_ok = ld_stb & wr_stb & ~cs;

    always_ff @(posedge clk) begin
        if (rst)          code_o <= '0;
        else if (load_ok) code_o <= bus_lo;
    end
endmodule

// File: rtl/rate_tap_div.sv
module rate_tap_div
    import rate_clk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    output tap_vec_t nxt_o,
    output tap_vec_t fall_o
);
    tap_vec_t cnt;

    assign nxt_o = cnt + 1'b1;

    // fall_o[k]: tap k goes from high to low at the coming edge
    for (genvar k = 0; k < DIV_W; k++) begin : g_fall
        assign fall_o[k] = cnt[k] & ~nxt_o[k];
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= nxt_o;
    end
endmodule

// File: rtl/rate_switch.sv
module rate_switch
    import rate_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rate_code_t code_i,
    input  tap_vec_t   nxt_i,
    input  tap_vec_t   fall_i,
    output logic       rate_clk_o,
    output rate_code_t active_o,
    output logic       busy_o
);
    sw_ctx_t ctx, ctx_n;
    logic    out_n;

    always_comb begin
        ctx_n = ctx;
        out_n = 1'b0;
        unique case (ctx.state)
            SW_RUN: begin
                out_n = nxt_i[ctx.sel];
                if (code_i != ctx.sel) ctx_n.state = SW_DRAIN;
            end
            SW_DRAIN: begin
                out_n = nxt_i[ctx.sel];
                if (code_i == ctx.sel) begin
                    ctx_n.state = SW_RUN;
                end else if (fall_i[ctx.sel]) begin
                    out_n       = 1'b0;
                    ctx_n.sel   = code_i;
                    ctx_n.falls = '0;
                    ctx_n.state = SW_WAIT;
                end
            end
            SW_WAIT: begin
                if (code_i != ctx.sel) begin
                    ctx_n.sel   = code_i;
                    ctx_n.falls = '0;
                end else if (fall_i[ctx.sel]) begin
                    if (ctx.falls == WCNT_W'(WAIT_FALLS - 1)) ctx_n.state = SW_RUN;
                    else ctx_n.falls = ctx.falls + 1'b1;
                end
            end
            default: ctx_n.state = SW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.state  <= SW_RUN;
            ctx.sel    <= '0;
            ctx.falls  <= '0;
            rate_clk_o <= 1'b0;
        end else begin
            ctx        <= ctx_n;
            rate_clk_o <= out_n;
        end
    end

    assign active_o = ctx.sel;
    assign busy_o   = (ctx.state != SW_RUN);
endmodule

// File: rtl/rate_clk_sel.sv
module rate_clk_sel
    import rate_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_lo,
    input  logic       ld_stb,
    input  logic       wr_stb,
    input  logic       cs,
    output logic [1:0] rate_code,
    output logic       rate_clk
);
    tap_vec_t   tap_nxt, tap_fall;
    rate_code_t active_sel;
    logic       sw_busy;

    rate_code_reg u_reg (
        .clk(clk), .rst(rst), .bus_lo(bus_lo), .ld_stb(ld_stb),
        .wr_stb(wr_stb), .cs(cs), .code_o(rate_code)
    );

    rate_tap_div u_div (
        .clk(clk), .rst(rst), .nxt_o(tap_nxt), .fall_o(tap_fall)
    );

    rate_switch u_sw (
        .clk(clk), .rst(rst), .code_i(rate_code), .nxt_i(tap_nxt),
        .fall_i(tap_fall), .rate_clk_o(rate_clk), .active_o(active_sel),
        .busy_o(sw_busy)
    );
endmodule

// File: rtl/rate_clk_sel_chk.sv
module rate_clk_sel_chk
    import rate_clk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_lo,
    input logic       ld_stb,
    input logic       wr_stb,
    input logic       cs,
    input logic [1:0] rate_code,
    input logic       rate_clk,
    input logic [1:0] active_sel,
    input logic       sw_busy
);
    logic [4:0] hi_len;
    logic [1:0] hi_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len <= '0;
            hi_sel <= '0;
        end else if (rate_clk) begin
            hi_len <= hi_len + 1'b1;
            if (hi_len == '0) hi_sel <= active_sel;
        end else begin
            hi_len <= '0;
        end
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && wr_stb && !cs) |=> (rate_code == $past(bus_lo))); // R2

    AST_CS_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (cs || !ld_stb || !wr_stb) |=> $stable(rate_code)); // R3

    AST_FULL_PULSE: assert property (@(posedge clk) disable iff (rst)
        $fell(rate_clk) |-> (32'(hi_len) == 32'(half_cycles(hi_sel)))); // R5

    AST_NO_SPURIOUS_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (!sw_busy && rate_code == active_sel && !(ld_stb && wr_stb && !cs)) |=> !sw_busy); // R7
endmodule

bind rate_clk_sel rate_clk_sel_chk u_chk (
    .clk(clk), .rst(rst), .bus_lo(bus_lo), .ld_stb(ld_stb), .wr_stb(wr_stb),
    .cs(cs), .rate_code(rate_code), .rate_clk(rate_clk),
    .active_sel(active_sel), .sw_busy(sw_busy)
);

// File: tb/tb_rate_clk_sel.sv
module tb_rate_clk_sel;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_lo = '0;
    logic       ld_stb = 1'b0, wr_stb = 1'b0, cs = 1'b0;
    logic [1:0] rate_code;
    logic       rate_clk;

    int total = 0, bad = 0;
    int exp_q[$];
    string tag_q[$];
    int max_low = 0;
    int hi = 0, lo = 0;
    logic prev = 1'b0;
    logic done = 1'b0;

    rate_clk_sel dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: measures pulses, pops expected widths
    always @(negedge clk) begin
        if (!rst) begin
            if (rate_clk) begin
                if (!prev) begin
                    if (lo > max_low) max_low = lo;
                    lo = 0; hi = 0;
                end
                hi++;
            end else begin
                if (prev) begin
                    if (exp_q.size() > 0) begin
                        int e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(hi == e, t, hi, e);
                    end
                    hi = 0; lo = 0;
                end
                lo++;
            end
            prev = rate_clk;
        end
    end

    task automatic write(input logic [1:0] v, input logic l, input logic w, input logic c);
        @(negedge clk);
        bus_lo = v; ld_stb = l; wr_stb = w; cs = c;
        @(negedge clk);
        ld_stb = 1'b0; wr_stb = 1'b0; cs = 1'b0;
    endtask

    task automatic expect_widths(input int code, input string tag);
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back(1 << code);
            tag_q.push_back(tag);
        end
        wait (exp_q.size() == 0);
    endtask

    task automatic change(input int from_c, input int to_c);
        write(2'(to_c), 1'b1, 1'b1, 1'b0);
        check(rate_code == 2'(to_c), "R2 capture", rate_code, to_c);
        max_low = 0;
        repeat (100) @(negedge clk);
        check(max_low >= 3 * (1 << to_c), "R6 gap low bound", max_low, 3 * (1 << to_c));
        check(max_low <= 2 * (1 << from_c) + 6 * (1 << to_c) + 2, "R6 gap high bound",
              max_low, 2 * (1 << from_c) + 6 * (1 << to_c) + 2);
        expect_widths(to_c, "R4/R5 width");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rate_code == 2'd0, "R1 code in reset", rate_code, 0);
        check(rate_clk == 1'b0, "R1 clk low in reset", rate_clk, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rate_code == 2'd0, "R1 code after reset", rate_code, 0);
        expect_widths(0, "R1 default width");

        change(0, 2);
        change(2, 3);
        change(3, 0);
        change(0, 1);

        // R3: blocked writes
        write(2'd3, 1'b1, 1'b1, 1'b1);
        check(rate_code == 2'd1, "R3 cs high", rate_code, 1);
        write(2'd3, 1'b1, 1'b0, 1'b0);
        check(rate_code == 2'd1, "R3 no write strobe", rate_code, 1);
        write(2'd3, 1'b0, 1'b1, 1'b0);
        check(rate_code == 2'd1, "R3 no load strobe", rate_code, 1);

        // R7: same-code write keeps the waveform
        write(2'd2, 1'b1, 1'b1, 1'b0);
        repeat (100) @(negedge clk);
        write(2'd2, 1'b1, 1'b1, 1'b0);
        max_low = 0;
        repeat (60) @(negedge clk);
        check(max_low == 4, "R7 no gap on same code", max_low, 4);
        expect_widths(2, "R7 width");

        // R8: retarget mid-switch
        write(2'd3, 1'b1, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        write(2'd0, 1'b1, 1'b1, 1'b0);
        repeat (120) @(negedge clk);
        check(rate_code == 2'd0, "R8 last code kept", rate_code, 0);
        expect_widths(0, "R8 width");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule